// File: doc/BRIEF.md
# Serial Flash Row-Programming Sequencer

This block writes code memory into a target microcontroller over a two-wire serial programming link. It drives a serial clock and a serial data line. A host hands it a 24-bit start address with a start pulse, then streams 24-bit instruction words through a valid/ready handshake. For every row of `ROW_WORDS` words, the block shifts out the fixed series of target instructions that program that row. It packs groups of four 24-bit words into six 16-bit register loads on its own, then loads the write latches and starts the row write.

The controller is a single state machine with eight named states. `ST_IDLE` waits for `start` and then moves to `ST_PREAMBLE`. `ST_PREAMBLE` sends five transfers that leave reset and arm row writing, then moves to `ST_ADDRESS`. `ST_ADDRESS` sends three transfers that load the destination, then moves to `ST_GATHER`. `ST_GATHER` takes four words, either from the host or as padding, then moves to `ST_LOAD`. `ST_LOAD` sends six register loads, then moves to `ST_LATCH`. `ST_LATCH` initialises the read pointer and sends eight table writes. It then returns to `ST_GATHER` for the next group, or moves to `ST_COMMIT` after the last group of the row. `ST_COMMIT` starts the write and sends the program counter back to 0x200. It then returns to `ST_ADDRESS` for the next row, or moves to `ST_DONE` after the final row. `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

A separate bit shifter handles each 28-bit transfer, and a packer module forms the register immediates.

Top module: `rowprog_seq`

## Requirements
- R1: Each transfer is 28 bits: a 4-bit command code 0000 followed by a 24-bit payload, both least significant bit first. The target samples `pgm_dat` on each rising edge of `pgm_clk`.
- R2: Each half of the serial clock lasts `half_period` system clocks, and a value of 0 acts as 1. `pgm_dat` changes only while `pgm_clk` is low, so it never changes across a rising edge or during a high phase.
- R3: After a start, the first five payloads are, in order: 0x000000, 0x040200, 0x000000, 0x24001A, 0x883B0A.
- R4: Each row begins with three payloads. The first is {0x200, A[23:16], 0x0}. The second is 0x883B0A's page-move companion 0x880190. The third is {0x2, A[15:0], 0x7}. Here A is the row address.
- R5: Each group of four words w0..w3 gives six payloads {0x2, imm, r} for r = 0 to 5. The immediates, in order, are: w0[15:0]; {w1[23:16], w0[23:16]}; w1[15:0]; w2[15:0]; {w3[23:16], w2[23:16]}; w3[15:0].
- R6: After each group's loads come 0xEB0300 and then eight table writes: 0xBB0BB6, 0xBBDBB6, 0xBBEBB6, 0xBB1BB6, repeated once. A row holds ROW_WORDS/4 groups.
- R7: Each row ends with 0xA8E761, 0x000000, 0x000000, 0x040200, 0x000000.
- R8: Each new row uses the previous row address plus 2*ROW_WORDS, modulo 2^24.
- R9: `word_ready` is high only while the block gathers words, and never while `pgm_clk` is high. A word is taken on a cycle with `word_valid` and `word_ready` both high.
- R10: Once a word with `word_last` has been taken, the rest of that row is filled with 0xFFFFFF without the handshake, and that row is the final row.
- R11: `done` is high for exactly one cycle after the final row's last transfer. `busy` is low the next cycle. A `start` while `busy` is high has no effect.
- R12: In reset and while idle, `pgm_clk`, `pgm_dat`, `word_ready`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming run (sampled when idle) |
| start_addr | input | 24 | Address of the first row |
| half_period | input | HALF_W | System clocks per serial clock half-phase |
| word_data | input | 24 | Instruction word from host |
| word_valid | input | 1 | `word_data` is valid |
| word_last | input | 1 | This word is the last of the stream |
| word_ready | output | 1 | Block takes a word this cycle if valid |
| pgm_clk | output | 1 | Serial programming clock |
| pgm_dat | output | 1 | Serial programming data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the block with ROW_WORDS = 8, which gives two groups per row. At that size, several rows, a stream that ends at a group boundary, an exact row boundary, a single-word run and an address wrap past 0xFFFFFF all fit in a few thousand cycles each. It sweeps `half_period` over 0 to 3 to cover the zero-as-one case and the phase timing. It decodes every transfer from the pins and compares it against an expected sequence computed from the packing and address rules.

// File: rtl/rowprog_pkg.sv
package rowprog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_ADDRESS,
        ST_GATHER,
        ST_LOAD,
        ST_LATCH,
        ST_COMMIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } shift_state_t;

    localparam int          CMD_W      = 4;
    localparam int          PAYLOAD_W  = 24;
    localparam int          XFER_W     = CMD_W + PAYLOAD_W;
    localparam logic [3:0]  CMD_EXEC   = 4'b0000;
    localparam logic [23:0] PAD_WORD   = 24'hFFFFFF;

    localparam int PREAMBLE_LEN = 5;
    localparam int ADDRESS_LEN  = 3;
    localparam int LOAD_LEN     = 6;
    localparam int LATCH_LEN    = 9;
    localparam int COMMIT_LEN   = 5;

    function automatic logic [23:0] preamble_payload(input logic [3:0] i);
        case (i)
            4'd1:    return 24'h040200;
            4'd3:    return 24'h24001A;
            4'd4:    return 24'h883B0A;
            default: return 24'h000000;
        endcase
    endfunction

    function automatic logic [23:0] latch_payload(input logic [3:0] i);
        case (i)
            4'd0:       return 24'hEB0300;
            4'd1, 4'd5: return 24'hBB0BB6;
            4'd2, 4'd6: return 24'hBBDBB6;
            4'd3, 4'd7: return 24'hBBEBB6;
            default:    return 24'hBB1BB6;
        endcase
    endfunction

    function automatic logic [23:0] commit_payload(input logic [3:0] i);
        case (i)
            4'd0:    return 24'hA8E761;
            4'd3:    return 24'h040200;
            default: return 24'h000000;
        endcase
    endfunction

endpackage

// File: rtl/rowprog_shifter.sv
module rowprog_shifter
    import rowprog_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [23:0]       payload,
    input  logic [HALF_W-1:0] half,
    output logic              busy,
    output logic              sclk,
    output logic              sdat,
    output logic              xfer_done
);

    localparam int BIT_W = $clog2(XFER_W);

    shift_state_t       st;
    logic [XFER_W-1:0]  sr;
    logic [BIT_W-1:0]   bitn;
    logic [HALF_W-1:0]  cnt;
    logic [HALF_W-1:0]  lim;

    // a programmed half period of zero behaves as one
    assign lim  = (half == '0) ? '0 : half - 1'b1;
    assign busy = (st != SH_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SH_IDLE;
            sr        <= '0;
            bitn      <= '0;
            cnt       <= '0;
            sclk      <= 1'b0;
            sdat      <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            unique case (st)
                SH_IDLE: begin
                    if (go) begin
                        sr   <= {payload, CMD_EXEC};
                        sdat <= CMD_EXEC[0];
                        bitn <= '0;
                        cnt  <= '0;
                        st   <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (cnt == lim) begin
                        cnt  <= '0;
                        sclk <= 1'b1;
                        st   <= SH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (cnt == lim) begin
                        cnt  <= '0;
                        sclk <= 1'b0;
                        if (bitn == BIT_W'(XFER_W - 1)) begin
                            sdat      <= 1'b0;
                            xfer_done <= 1'b1;
                            st        <= SH_IDLE;
                        end else begin
                            // new bit goes out together with the falling edge
                            sr   <= sr >> 1;
                            sdat <= sr[1];
                            bitn <= bitn + 1'b1;
                            st   <= SH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rowprog_packer.sv
module rowprog_packer
    import rowprog_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_slot,
    input  logic [23:0] wr_word,
    input  logic [2:0]  sel,
    output logic [15:0] imm
);

    localparam int PAIRS = WORDS / 2;

    logic [23:0] word_q [WORDS];
    logic [15:0] packed_imm [8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
        end else if (wr_en) begin
            word_q[wr_slot] <= wr_word;
        end
    end

    // each pair of words becomes three immediates: low, shared high bytes, low
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign packed_imm[3*p]     = word_q[2*p][15:0];
        assign packed_imm[3*p + 1] = {word_q[2*p + 1][23:16], word_q[2*p][23:16]};
        assign packed_imm[3*p + 2] = word_q[2*p + 1][15:0];
    end
    for (genvar u = 3 * PAIRS; u < 8; u++) begin : g_unused
        assign packed_imm[u] = '0;
    end

    assign imm = packed_imm[sel];

endmodule

// File: rtl/rowprog_seq.sv
module rowprog_seq
    import rowprog_pkg::*;
#(
    parameter int ROW_WORDS = 64,
    parameter int HALF_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [23:0]       start_addr,
    input  logic [HALF_W-1:0] half_period,
    input  logic [23:0]       word_data,
    input  logic              word_valid,
    input  logic              word_last,
    output logic              word_ready,
    output logic              pgm_clk,
    output logic              pgm_dat,
    output logic              busy,
    output logic              done
);

    localparam int          GROUP_WORDS = 4;
    localparam int          GROUPS      = ROW_WORDS / GROUP_WORDS;
    localparam int          GW          = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [23:0] ROW_STEP    = 24'(2 * ROW_WORDS);

    seq_state_t    state, state_n;
    logic [3:0]    idx;
    logic          launched;
    logic [23:0]   addr;
    logic [GW-1:0] grp;
    logic [1:0]    wcnt;
    logic          pad;
    logic          final_row;

    logic          emit, phase_last, grp_last, word_take;
    logic          xfer_go, sh_busy, xfer_done;
    logic [23:0]   payload;
    logic [15:0]   imm;
    logic [3:0]    phase_len;

    rowprog_shifter #(.HALF_W(HALF_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (xfer_go),
        .payload   (payload),
        .half      (half_period),
        .busy      (sh_busy),
        .sclk      (pgm_clk),
        .sdat      (pgm_dat),
        .xfer_done (xfer_done)
    );

    rowprog_packer #(.WORDS(GROUP_WORDS)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (word_take),
        .wr_slot (wcnt),
        .wr_word (pad ? PAD_WORD : word_data),
        .sel     (idx[2:0]),
        .imm     (imm)
    );

    // ---------------- state register and datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            launched  <= 1'b0;
            addr      <= '0;
            grp       <= '0;
            wcnt      <= '0;
            pad       <= 1'b0;
            final_row <= 1'b0;
        end else begin
            state <= state_n;
            if (xfer_go)   launched <= 1'b1;
            if (xfer_done) begin
                launched <= 1'b0;
                idx      <= phase_last ? '0 : idx + 1'b1;
            end
            if (state == ST_IDLE && start) begin
                addr      <= start_addr;
                grp       <= '0;
                wcnt      <= '0;
                pad       <= 1'b0;
                final_row <= 1'b0;
            end
            if (word_take) begin
                wcnt <= wcnt + 1'b1;
                if (!pad && word_last) begin
                    pad       <= 1'b1;
                    final_row <= 1'b1;
                end
            end
            if (state == ST_LATCH && xfer_done && phase_last)
                grp <= grp_last ? '0 : grp + 1'b1;
            if (state == ST_COMMIT && xfer_done && phase_last)
                addr <= addr + ROW_STEP;
        end
    end

    // ---------------- next state and outputs ----------------
    always_comb begin
        emit = (state == ST_PREAMBLE) || (state == ST_ADDRESS) || (state == ST_LOAD) ||
               (state == ST_LATCH)    || (state == ST_COMMIT);

        unique case (state)
            ST_PREAMBLE: phase_len = 4'(PREAMBLE_LEN);
            ST_ADDRESS:  phase_len = 4'(ADDRESS_LEN);
            ST_LOAD:     phase_len = 4'(LOAD_LEN);
            ST_LATCH:    phase_len = 4'(LATCH_LEN);
            ST_COMMIT:   phase_len = 4'(COMMIT_LEN);
            default:     phase_len = 4'd1;
        endcase
        phase_last = (idx == phase_len - 1'b1);
        grp_last   = (grp == GW'(GROUPS - 1));

        word_ready = (state == ST_GATHER) && !pad;
        word_take  = (state == ST_GATHER) && (pad || word_valid);
        xfer_go    = emit && !launched && !sh_busy;
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);

        unique case (state)
            ST_PREAMBLE: payload = preamble_payload(idx);
            ST_ADDRESS: begin
                unique case (idx)
                    4'd0:    payload = {12'h200, addr[23:16], 4'h0};
                    4'd1:    payload = 24'h880190;
                    default: payload = {4'h2, addr[15:0], 4'h7};
                endcase
            end
            ST_LOAD:     payload = {4'h2, imm, idx};
            ST_LATCH:    payload = latch_payload(idx);
            ST_COMMIT:   payload = commit_payload(idx);
            default:     payload = '0;
        endcase

        state_n = state;
        unique case (state)
            ST_IDLE:     if (start) state_n = ST_PREAMBLE;
            ST_PREAMBLE: if (xfer_done && phase_last) state_n = ST_ADDRESS;
            ST_ADDRESS:  if (xfer_done && phase_last) state_n = ST_GATHER;
            ST_GATHER:   if (word_take && wcnt == 2'd3) state_n = ST_LOAD;
            ST_LOAD:     if (xfer_done && phase_last) state_n = ST_LATCH;
            ST_LATCH:    if (xfer_done && phase_last) state_n = grp_last ? ST_COMMIT : ST_GATHER;
            ST_COMMIT:   if (xfer_done && phase_last) state_n = final_row ? ST_DONE : ST_ADDRESS;
            ST_DONE:     state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/rowprog_checker.sv
module rowprog_checker (
    input logic clk,
    input logic rst_n,
    input logic word_ready,
    input logic pgm_clk,
    input logic pgm_dat,
    input logic busy,
    input logic done
);

    a_r2_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_clk && $past(pgm_clk)) |-> $stable(pgm_dat));

    a_r2_rise_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_clk) |-> $stable(pgm_dat));

    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (!pgm_clk && busy));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pgm_clk && !word_ready && !done));

endmodule

bind rowprog_seq rowprog_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_ready (word_ready),
    .pgm_clk    (pgm_clk),
    .pgm_dat    (pgm_dat),
    .busy       (busy),
    .done       (done)
);

// File: tb/tb_rowprog_seq.sv
`timescale 1ns/1ps
module tb_rowprog_seq;

    localparam int RW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [7:0]  half_period = 8'd1;
    logic [23:0] word_data = '0;
    logic        word_valid = 1'b0;
    logic        word_last = 1'b0;
    logic        word_ready, pgm_clk, pgm_dat, busy, done;

    always #4 clk = ~clk;

    rowprog_seq #(.ROW_WORDS(RW), .HALF_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .half_period(half_period), .word_data(word_data), .word_valid(word_valid),
        .word_last(word_last), .word_ready(word_ready), .pgm_clk(pgm_clk),
        .pgm_dat(pgm_dat), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [27:0] rec [0:255];
    int          rec_n = 0;
    logic [27:0] shreg = '0;
    int          bitc = 0;
    logic [23:0] exp_p [0:255];
    string       exp_t [0:255];
    int          exp_n = 0;

    int  hi_cnt = 0, exp_hi = 1;
    int  hi_viol = 0, dat_viol = 0, rdy_viol = 0, done_cnt = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%07h expected 0x%07h", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // decode serial records on the target's sampling edge (R1)
    always @(posedge pgm_clk) begin
        shreg = {pgm_dat, shreg[27:1]};
        bitc++;
        if (bitc == 28) begin
            if (rec_n < 256) rec[rec_n] = shreg;
            rec_n++;
            bitc = 0;
        end
    end

    // phase timing, data stability and ready/quiet monitoring (R2, R9, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (pgm_clk) begin
                hi_cnt++;
                if (pgm_dat !== prev_dat) dat_viol++;
            end else begin
                if (prev_clk && hi_cnt != exp_hi) hi_viol++;
                hi_cnt = 0;
            end
            if (word_ready && pgm_clk) rdy_viol++;
            if (done) done_cnt++;
        end
        prev_clk = pgm_clk;
        prev_dat = pgm_dat;
    end

    function automatic logic [23:0] gen_word(input int t, input int k);
        return 24'((k * 24'h0A3C5F) + (t * 24'h111111) + 24'h80F00D);
    endfunction

    task automatic push(input logic [23:0] p, input string tag);
        exp_p[exp_n] = p;
        exp_t[exp_n] = tag;
        exp_n++;
    endtask

    task automatic build(input int t, input logic [23:0] a0, input int n);
        int rows;
        exp_n = 0;
        rows = (n + RW - 1) / RW;
        push(24'h000000, "R3"); push(24'h040200, "R3"); push(24'h000000, "R3");
        push(24'h24001A, "R3"); push(24'h883B0A, "R3");
        for (int r = 0; r < rows; r++) begin
            logic [23:0] a;
            a = 24'(a0 + r * 2 * RW);
            push({12'h200, a[23:16], 4'h0}, (r > 0) ? "R8" : "R4");
            push(24'h880190, "R4");
            push({4'h2, a[15:0], 4'h7}, (r > 0) ? "R8" : "R4");
            for (int g = 0; g < RW / 4; g++) begin
                logic [23:0] w [4];
                logic [15:0] im [6];
                bit padded;
                padded = 0;
                for (int j = 0; j < 4; j++) begin
                    int k;
                    k = r * RW + g * 4 + j;
                    w[j] = (k < n) ? gen_word(t, k) : 24'hFFFFFF;
                    if (k >= n) padded = 1;
                end
                im[0] = w[0][15:0]; im[1] = {w[1][23:16], w[0][23:16]}; im[2] = w[1][15:0];
                im[3] = w[2][15:0]; im[4] = {w[3][23:16], w[2][23:16]}; im[5] = w[3][15:0];
                for (int j = 0; j < 6; j++) push({4'h2, im[j], 4'(j)}, padded ? "R10" : "R5");
                push(24'hEB0300, "R6");
                for (int q = 0; q < 2; q++) begin
                    push(24'hBB0BB6, "R6"); push(24'hBBDBB6, "R6");
                    push(24'hBBEBB6, "R6"); push(24'hBB1BB6, "R6");
                end
            end
            push(24'hA8E761, "R7"); push(24'h000000, "R7"); push(24'h000000, "R7");
            push(24'h040200, "R7"); push(24'h000000, "R7");
        end
    endtask

    task automatic drive(input int t, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            word_data  = gen_word(t, k);
            word_last  = (k == n - 1);
            word_valid = 1'b1;
            while (!word_ready) @(negedge clk);
            @(negedge clk);
            word_valid = 1'b0;
            word_last  = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic run(input int t, input logic [23:0] a0, input int n, input int h, input int gap, input bit poke);
        int d0, hv0, dv0, rv0;
        build(t, a0, n);
        rec_n = 0; bitc = 0;
        half_period = 8'(h);
        exp_hi = (h == 0) ? 1 : h;
        d0 = done_cnt; hv0 = hi_viol; dv0 = dat_viol; rv0 = rdy_viol;
        @(negedge clk);
        start = 1'b1; start_addr = a0;
        @(negedge clk);
        start = 1'b0;
        fork
            drive(t, n, gap);
            begin
                if (poke) begin
                    repeat (400) @(negedge clk);
                    start = 1'b1; start_addr = 24'h555550;   // R11: ignored while busy
                    @(negedge clk);
                    start = 1'b0;
                end
            end
            begin
                while (!done) @(negedge clk);
                @(negedge clk);
                check(busy == 1'b0, "R11 busy after done", 28'(busy), 28'd0);
            end
        join
        check(done_cnt - d0 == 1, "R11 done pulse width", 28'(done_cnt - d0), 28'd1);
        check(hi_viol == hv0, "R2 high phase length", 28'(hi_viol - hv0), 28'd0);
        check(dat_viol == dv0, "R2 data stable while high", 28'(dat_viol - dv0), 28'd0);
        check(rdy_viol == rv0, "R9 ready during shifting", 28'(rdy_viol - rv0), 28'd0);
        check(rec_n == exp_n, "R1 transfer count", 28'(rec_n), 28'(exp_n));
        for (int i = 0; i < exp_n && i < rec_n; i++)
            check(rec[i] == {exp_p[i], 4'b0000}, exp_t[i], rec[i], {exp_p[i], 4'b0000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pgm_clk == 0, "R12 reset pgm_clk", 28'(pgm_clk), 28'd0);
        check(pgm_dat == 0, "R12 reset pgm_dat", 28'(pgm_dat), 28'd0);
        check(word_ready == 0, "R12 reset word_ready", 28'(word_ready), 28'd0);
        check(done == 0 && busy == 0, "R12 reset done/busy", 28'({done, busy}), 28'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && pgm_clk == 0, "R12 idle after reset", 28'({busy, pgm_clk}), 28'd0);
        run(1, 24'h012340, 8,  1, 0, 1'b0);   // one full row
        run(2, 24'hFFFFF8, 11, 2, 3, 1'b1);   // wrap, padding mid-row, ignored start
        run(3, 24'h7A0000, 1,  0, 0, 1'b0);   // single word, zero half period
        run(4, 24'h000200, 16, 3, 1, 1'b0);   // last word on a row boundary
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule